// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line Error Flags

This block turns an asynchronous serial line into data words. A 16x oversampling tick enable paces it. It waits for the line to fall from idle high, confirms the start bit at its centre, and samples each later bit near its centre. It removes the start, parity and stop bits. The data bits go into one holding register, together with a set of status flags. The flags report data ready, overrun, parity error, framing error and break.

The word length and the parity settings are the same format controls that the matching transmitter uses, so one configuration serves both directions. The host gives a one-cycle data-read strobe when it takes the word, and a one-cycle status-read strobe when it reads the flags. The error flags stay set until the status read. If a new word arrives before the host has read the old one, the new word replaces the old one and the overrun flag records the loss.

Top module: `serial_rx`

## Requirements
- R1: Bits are taken least significant first, and only the data bits appear on `rxData`. A frame with a good stop bit delivers exactly the data that was sent.
- R2: If the line is high again at the centre of a candidate start bit, the receiver goes back to waiting for a falling edge. It stores no word and changes no flag.
- R3: With `parityEn` set, the receiver checks the parity bit that follows the data. With stick off, `parityEven` = 1 expects an even number of ones across data plus parity, and `parityEven` = 0 expects an odd number. With stick on, the parity bit must be 0 when `parityEven` = 1 and 1 when `parityEven` = 0. A mismatch sets `parityErr` for that word.
- R4: When the stop-bit sample is 0 and at least one earlier sample of the frame was 1, the word is stored and `framingErr` is set.
- R5: When every sample of a frame reads 0, including the stop sample, the receiver stores a zero word and sets `breakInt`. That word sets neither `framingErr` nor `parityErr`.
- R6: After a stop sample of 0, the receiver waits for the line to go high before it looks for a new start bit. A long break therefore stores exactly one word.
- R7: `wordLen` selects the word length: 0, 1, 2 and 3 give 5, 6, 7 and 8 data bits. Shorter words are zero-extended in `rxData`.
- R8: `dataReady` rises only in the cycle after the stop-bit sample stores a word. A `hostReadData` strobe clears it.
- R9: If a word is stored while `dataReady` is still set and not being read in that cycle, `overrunErr` is set and `rxData` takes the newer word.
- R10: `parityErr`, `framingErr`, `breakInt` and `overrunErr` stay set until a `hostReadStatus` strobe. A data read alone leaves them set. If a store and a status read fall in the same cycle, the store wins.
- R11: After reset, `dataReady`, all four error flags and `rxData` are 0.
- R12: The receiver checks only one stop bit. A start bit that comes straight after it is accepted as the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleTick | input | 1 | Oversampling enable, 16 pulses per bit time |
| rxLine | input | 1 | Serial input, idle high |
| wordLen | input | 2 | Data bits minus five |
| parityEn | input | 1 | A parity bit follows the data |
| parityEven | input | 1 | Even (1) or odd (0) parity select |
| parityStick | input | 1 | Fixed parity value, see R3 |
| hostReadData | input | 1 | Host takes the held word |
| hostReadStatus | input | 1 | Host reads and clears the error flags |
| rxData | output | 8 | Held word, zero-extended |
| dataReady | output | 1 | Held word not yet read |
| overrunErr | output | 1 | A word was lost |
| parityErr | output | 1 | Parity mismatch seen |
| framingErr | output | 1 | Stop sample was 0 |
| breakInt | output | 1 | Whole frame read as 0 |

## Verification
The bench uses the default parameters: 16 ticks per bit, 8-bit data maximum and a two-stage synchronizer. It holds `sampleTick` high on every clock, so one bit lasts 16 clocks. With these settings a frame takes under 200 cycles. That makes it practical to cover all four word lengths, every parity mode including both stick values, back-to-back frames, a glitch shorter than half a bit, a twelve-bit-long break, and overrun with the host held off, all in one short run.

// File: rtl/rx_pkg.sv
package rx_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_WAITHIGH
  } rxStateT;

  // one-cycle strobes from control to datapath
  typedef struct packed {
    logic clearAcc;      // new frame: clear shift and accumulators
    logic shiftBit;      // sample a data bit into the shift register
    logic sampleParity;  // sample and judge the parity bit
    logic loadWord;      // stop sample: move word into holding register
  } rxStrobeT;

endpackage

// File: rtl/rx_control.sv
module rx_control
  import rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_MAX   = 8,
  parameter int LEN_W      = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleTick,
  input  logic             lineS,
  input  logic [LEN_W-1:0] wordLen,
  input  logic             parityEn,
  output rxStrobeT         strb
);

  localparam int CNT_W    = $clog2(OVERSAMPLE);
  localparam int BIT_W    = $clog2(DATA_MAX + 1);
  localparam int HALF     = OVERSAMPLE / 2;
  localparam int MIN_BITS = DATA_MAX - (2 ** LEN_W) + 1;

  rxStateT state, stateNext;
  logic [CNT_W-1:0] tickCnt, tickNext;
  logic [BIT_W-1:0] bitCnt, bitNext;
  logic [BIT_W-1:0] wordBits;
  logic lastTick, midTick;

  assign wordBits = BIT_W'(MIN_BITS) + BIT_W'(wordLen);
  assign lastTick = (tickCnt == CNT_W'(OVERSAMPLE - 1));
  assign midTick  = (tickCnt == CNT_W'(HALF - 1));

  always_comb begin
    stateNext = state;
    tickNext  = tickCnt;
    bitNext   = bitCnt;
    strb      = '0;
    if (sampleTick) begin
      case (state)
        ST_HUNT: begin
          if (!lineS) begin
            stateNext     = ST_START;
            tickNext      = '0;
            strb.clearAcc = 1'b1;
          end
        end
        ST_START: begin
          if (midTick) begin
            tickNext  = '0;
            bitNext   = '0;
            stateNext = lineS ? ST_HUNT : ST_DATA;
          end else begin
            tickNext = tickCnt + CNT_W'(1);
          end
        end
        ST_DATA: begin
          if (lastTick) begin
            strb.shiftBit = 1'b1;
            tickNext      = '0;
            bitNext       = bitCnt + BIT_W'(1);
            if (bitCnt == wordBits - BIT_W'(1))
              stateNext = parityEn ? ST_PARITY : ST_STOP;
          end else begin
            tickNext = tickCnt + CNT_W'(1);
          end
        end
        ST_PARITY: begin
          if (lastTick) begin
            strb.sampleParity = 1'b1;
            tickNext          = '0;
            stateNext         = ST_STOP;
          end else begin
            tickNext = tickCnt + CNT_W'(1);
          end
        end
        ST_STOP: begin
          if (lastTick) begin
            strb.loadWord = 1'b1;
            tickNext      = '0;
            stateNext     = lineS ? ST_HUNT : ST_WAITHIGH;
          end else begin
            tickNext = tickCnt + CNT_W'(1);
          end
        end
        ST_WAITHIGH: begin
          if (lineS) stateNext = ST_HUNT;
        end
        default: stateNext = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_HUNT;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      state   <= stateNext;
      tickCnt <= tickNext;
      bitCnt  <= bitNext;
    end
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb)); // R1

  AST_WAIT_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAITHIGH && !lineS) |=> (state == ST_WAITHIGH)); // R6

  AST_LOAD_FROM_STOP: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadWord |=> (state == ST_HUNT || state == ST_WAITHIGH)); // R12

endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import rx_pkg::*;
#(
  parameter int DATA_MAX    = 8,
  parameter int LEN_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxLine,
  input  rxStrobeT            strb,
  input  logic [LEN_W-1:0]    wordLen,
  input  logic                parityEven,
  input  logic                parityStick,
  input  logic                hostReadData,
  input  logic                hostReadStatus,
  output logic                lineS,
  output logic [DATA_MAX-1:0] rxData,
  output logic                dataReady,
  output logic                overrunErr,
  output logic                parityErr,
  output logic                framingErr,
  output logic                breakInt
);

  localparam int LEN_TOP = (2 ** LEN_W) - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [DATA_MAX-1:0]    shiftReg;
  logic                   dataXor;
  logic                   allZero;
  logic                   parBad;
  logic                   expParity;
  logic                   isBreak;
  logic [DATA_MAX-1:0]    alignedWord;

  // synchronizer for the asynchronous input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
  end
  assign lineS = syncQ[SYNC_STAGES-1];

  assign expParity   = parityStick ? ~parityEven : (parityEven ? dataXor : ~dataXor);
  assign isBreak     = allZero & ~lineS;
  assign alignedWord = shiftReg >> (LEN_TOP - int'(wordLen));

  // shift register and frame accumulators
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      dataXor  <= 1'b0;
      allZero  <= 1'b1;
      parBad   <= 1'b0;
    end else if (strb.clearAcc) begin
      shiftReg <= '0;
      dataXor  <= 1'b0;
      allZero  <= 1'b1;
      parBad   <= 1'b0;
    end else if (strb.shiftBit) begin
      shiftReg <= {lineS, shiftReg[DATA_MAX-1:1]};
      dataXor  <= dataXor ^ lineS;
      allZero  <= allZero & ~lineS;
    end else if (strb.sampleParity) begin
      parBad  <= (lineS != expParity);
      allZero <= allZero & ~lineS;
    end
  end

  // holding register and host-visible flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      dataReady  <= 1'b0;
      overrunErr <= 1'b0;
      parityErr  <= 1'b0;
      framingErr <= 1'b0;
      breakInt   <= 1'b0;
    end else begin
      if (strb.loadWord) begin
        rxData    <= isBreak ? '0 : alignedWord;
        dataReady <= 1'b1;
      end else if (hostReadData) begin
        dataReady <= 1'b0;
      end

      if (strb.loadWord && dataReady && !hostReadData) overrunErr <= 1'b1;
      else if (hostReadStatus)                         overrunErr <= 1'b0;

      if (strb.loadWord && !isBreak && parBad) parityErr <= 1'b1;
      else if (hostReadStatus)                 parityErr <= 1'b0;

      if (strb.loadWord && !isBreak && !lineS) framingErr <= 1'b1;
      else if (hostReadStatus)                 framingErr <= 1'b0;

      if (strb.loadWord && isBreak) breakInt <= 1'b1;
      else if (hostReadStatus)      breakInt <= 1'b0;
    end
  end

  AST_READY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadWord |=> dataReady); // R8

  AST_READY_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataReady) |-> $past(strb.loadWord)); // R8

  AST_OVERRUN_ON_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunErr) |-> $past(dataReady)); // R9

  AST_BREAK_NULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(breakInt) |-> (rxData == '0)); // R5

  AST_BREAK_NOT_FRAMING: assert property (@(posedge clk) disable iff (!rstN)
    $rose(breakInt) |-> !$rose(framingErr)); // R5

  AST_PARITY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr && !hostReadStatus) |=> parityErr); // R10

  AST_FRAMING_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (framingErr && !hostReadStatus) |=> framingErr); // R10

endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_MAX    = 8,
  parameter int LEN_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleTick,
  input  logic                rxLine,
  input  logic [LEN_W-1:0]    wordLen,
  input  logic                parityEn,
  input  logic                parityEven,
  input  logic                parityStick,
  input  logic                hostReadData,
  input  logic                hostReadStatus,
  output logic [DATA_MAX-1:0] rxData,
  output logic                dataReady,
  output logic                overrunErr,
  output logic                parityErr,
  output logic                framingErr,
  output logic                breakInt
);

  rxStrobeT strb;
  logic     lineS;

  rx_control #(
    .OVERSAMPLE(OVERSAMPLE),
    .DATA_MAX  (DATA_MAX),
    .LEN_W     (LEN_W)
  ) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .sampleTick(sampleTick),
    .lineS     (lineS),
    .wordLen   (wordLen),
    .parityEn  (parityEn),
    .strb      (strb)
  );

  rx_datapath #(
    .DATA_MAX   (DATA_MAX),
    .LEN_W      (LEN_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .rxLine        (rxLine),
    .strb          (strb),
    .wordLen       (wordLen),
    .parityEven    (parityEven),
    .parityStick   (parityStick),
    .hostReadData  (hostReadData),
    .hostReadStatus(hostReadStatus),
    .lineS         (lineS),
    .rxData        (rxData),
    .dataReady     (dataReady),
    .overrunErr    (overrunErr),
    .parityErr     (parityErr),
    .framingErr    (framingErr),
    .breakInt      (breakInt)
  );

endmodule

// File: tb/serial_rx_bench.sv
module serial_rx_bench;

  localparam int BIT_CYC = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleTick = 1'b1;
  logic rxLine = 1'b1;
  logic [1:0] wordLen = 2'd3;
  logic parityEn = 1'b0;
  logic parityEven = 1'b1;
  logic parityStick = 1'b0;
  logic autoRdData = 1'b0, autoRdStatus = 1'b0;
  logic manRdData = 1'b0, manRdStatus = 1'b0;
  logic hostReadData, hostReadStatus;
  logic [7:0] rxData;
  logic dataReady, overrunErr, parityErr, framingErr, breakInt;

  assign hostReadData   = autoRdData | manRdData;
  assign hostReadStatus = autoRdStatus | manRdStatus;

  always #10 clk = ~clk;  // 50 MHz

  serial_rx u_serial_rx (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .wordLen(wordLen), .parityEn(parityEn), .parityEven(parityEven),
    .parityStick(parityStick), .hostReadData(hostReadData),
    .hostReadStatus(hostReadStatus), .rxData(rxData), .dataReady(dataReady),
    .overrunErr(overrunErr), .parityErr(parityErr), .framingErr(framingErr),
    .breakInt(breakInt)
  );

  typedef struct packed {
    logic [7:0] data;
    logic pe;
    logic fe;
    logic brk;
  } expT;

  expT   expQ[$];
  string tagQ[$];
  int    totalChecks = 0;
  int    failChecks  = 0;
  logic  autoRead    = 1'b0;
  logic  done        = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    totalChecks++;
    if (act !== exp) begin
      failChecks++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic parityFor(input logic [7:0] d, input int n,
                                     input logic even, input logic stick);
    logic x;
    x = 1'b0;
    for (int i = 0; i < n; i++) x ^= d[i];
    if (stick) return ~even;
    return even ? x : ~x;
  endfunction

  task automatic holdLine(input logic v, input int cycles);
    rxLine = v;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input int n, input logic parOn,
                           input logic parBit, input logic stopBit);
    holdLine(1'b0, BIT_CYC);
    for (int i = 0; i < n; i++) holdLine(d[i], BIT_CYC);
    if (parOn) holdLine(parBit, BIT_CYC);
    holdLine(stopBit, BIT_CYC);
    rxLine = 1'b1;
  endtask

  task automatic expectWord(input logic [7:0] d, input logic pe, input logic fe,
                            input logic brk, input string tag);
    expT e;
    e.data = d; e.pe = pe; e.fe = fe; e.brk = brk;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic pulseData();
    manRdData = 1'b1; @(negedge clk); manRdData = 1'b0;
  endtask

  task automatic pulseStatus();
    manRdStatus = 1'b1; @(negedge clk); manRdStatus = 1'b0;
  endtask

  // monitor: pops the scoreboard and reads the word back like a host
  initial begin
    forever begin
      @(negedge clk);
      if (autoRead && dataReady) begin
        if (expQ.size() == 0) begin
          check("R2/R6 unexpected word", 32'(rxData), 32'hDEAD);
        end else begin
          expT   e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check({t, " data"},    32'(rxData),     32'(e.data));
          check({t, " parity"},  32'(parityErr),  32'(e.pe));
          check({t, " framing"}, 32'(framingErr), 32'(e.fe));
          check({t, " break"},   32'(breakInt),   32'(e.brk));
          check({t, " overrun"}, 32'(overrunErr), 32'd0);
        end
        autoRdData = 1'b1; autoRdStatus = 1'b1;
        @(negedge clk);
        autoRdData = 1'b0; autoRdStatus = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      totalChecks++;
      failChecks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 dataReady", 32'(dataReady), 0);
    check("R11 flags", 32'({overrunErr, parityErr, framingErr, breakInt}), 0);
    check("R11 rxData", 32'(rxData), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    autoRead = 1'b1;

    // R1, R12: 8-bit words, no parity, back to back with one stop bit
    expectWord(8'hA5, 0, 0, 0, "R1 a5");   sendFrame(8'hA5, 8, 0, 0, 1);
    expectWord(8'h3C, 0, 0, 0, "R12 3c");  sendFrame(8'h3C, 8, 0, 0, 1);
    expectWord(8'hFF, 0, 0, 0, "R12 ff");  sendFrame(8'hFF, 8, 0, 0, 1);
    expectWord(8'h00, 0, 0, 0, "R1 00");   sendFrame(8'h00, 8, 0, 0, 1);
    holdLine(1'b1, BIT_CYC);
    drain();

    // R7: shorter words are zero-extended
    wordLen = 2'd0;
    expectWord(8'h15, 0, 0, 0, "R7 len5"); sendFrame(8'hF5, 5, 0, 0, 1);
    holdLine(1'b1, BIT_CYC); drain();
    wordLen = 2'd1;
    expectWord(8'h2A, 0, 0, 0, "R7 len6"); sendFrame(8'hEA, 6, 0, 0, 1);
    holdLine(1'b1, BIT_CYC); drain();
    wordLen = 2'd2;
    expectWord(8'h5A, 0, 0, 0, "R7 len7"); sendFrame(8'hDA, 7, 0, 0, 1);
    holdLine(1'b1, BIT_CYC); drain();

    // R3: parity modes, good and bad
    wordLen = 2'd3; parityEn = 1'b1;
    parityEven = 1'b1; parityStick = 1'b0;
    expectWord(8'h37, 0, 0, 0, "R3 even ok");
    sendFrame(8'h37, 8, 1, parityFor(8'h37, 8, 1, 0), 1);
    expectWord(8'h37, 1, 0, 0, "R3 even bad");
    sendFrame(8'h37, 8, 1, ~parityFor(8'h37, 8, 1, 0), 1);
    holdLine(1'b1, BIT_CYC); drain();
    parityEven = 1'b0;
    expectWord(8'h81, 0, 0, 0, "R3 odd ok");
    sendFrame(8'h81, 8, 1, parityFor(8'h81, 8, 0, 0), 1);
    expectWord(8'h81, 1, 0, 0, "R3 odd bad");
    sendFrame(8'h81, 8, 1, ~parityFor(8'h81, 8, 0, 0), 1);
    holdLine(1'b1, BIT_CYC); drain();
    parityStick = 1'b1; parityEven = 1'b1;
    expectWord(8'h0F, 0, 0, 0, "R3 stick0 ok");  sendFrame(8'h0F, 8, 1, 0, 1);
    expectWord(8'h0F, 1, 0, 0, "R3 stick0 bad"); sendFrame(8'h0F, 8, 1, 1, 1);
    holdLine(1'b1, BIT_CYC); drain();
    parityEven = 1'b0;
    expectWord(8'h0F, 0, 0, 0, "R3 stick1 ok");  sendFrame(8'h0F, 8, 1, 1, 1);
    expectWord(8'h0F, 1, 0, 0, "R3 stick1 bad"); sendFrame(8'h0F, 8, 1, 0, 1);
    holdLine(1'b1, BIT_CYC); drain();
    parityEn = 1'b0; parityStick = 1'b0; parityEven = 1'b1;

    // R4: framing error, then R6 wait for high
    expectWord(8'h81, 0, 1, 0, "R4 framing"); sendFrame(8'h81, 8, 0, 0, 0);
    holdLine(1'b1, 3 * BIT_CYC); drain();

    // R5, R6: long break stores one null word
    expectWord(8'h00, 0, 0, 1, "R5 break");
    holdLine(1'b0, 12 * BIT_CYC);
    holdLine(1'b1, 3 * BIT_CYC); drain();
    check("R6 one word per break", 32'(expQ.size()), 0);
    check("R6 no extra ready", 32'(dataReady), 0);

    // R2: glitch shorter than half a bit
    holdLine(1'b0, 4);
    holdLine(1'b1, 3 * BIT_CYC);
    check("R2 glitch ready", 32'(dataReady), 0);
    check("R2 glitch flags", 32'({parityErr, framingErr, breakInt}), 0);
    expectWord(8'h66, 0, 0, 0, "R2 after glitch"); sendFrame(8'h66, 8, 0, 0, 1);
    holdLine(1'b1, BIT_CYC); drain();

    // R8, R9: host held off, two words arrive
    autoRead = 1'b0;
    fork
      sendFrame(8'h11, 8, 0, 0, 1);
      begin
        repeat (9 * BIT_CYC) @(negedge clk);
        check("R8 not ready mid-frame", 32'(dataReady), 0);
      end
    join
    holdLine(1'b1, BIT_CYC);
    check("R8 ready after frame", 32'(dataReady), 1);
    check("R8 first word", 32'(rxData), 32'h11);
    sendFrame(8'h22, 8, 0, 0, 1);
    holdLine(1'b1, BIT_CYC);
    check("R9 overrun set", 32'(overrunErr), 1);
    check("R9 newer word kept", 32'(rxData), 32'h22);
    pulseStatus();
    check("R10 overrun cleared by status", 32'(overrunErr), 0);
    check("R10 status keeps ready", 32'(dataReady), 1);
    pulseData();
    check("R8 ready cleared by read", 32'(dataReady), 0);

    // R10: parity error survives a data read, cleared by status read
    parityEn = 1'b1; parityEven = 1'b1;
    sendFrame(8'h01, 8, 1, ~parityFor(8'h01, 8, 1, 0), 1);
    holdLine(1'b1, BIT_CYC);
    check("R3 manual parity flag", 32'(parityErr), 1);
    pulseData();
    check("R10 data read keeps parityErr", 32'(parityErr), 1);
    pulseStatus();
    check("R10 status clears parityErr", 32'(parityErr), 0);
    parityEn = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
    $finish;
  end

endmodule